// File: doc/BRIEF.md
# Rank Boundary Address Decoder

This block maps a physical memory address onto one DRAM rank of two independent channels. Software programs eight 8-bit boundary registers, four per channel. Each register holds the cumulative upper limit of its rank in 32 MB steps. The ranks of the second channel carry on from the top of the first channel's last rank, so together the eight limits divide one flat address space into contiguous regions. The decoder compares bits [31:25] of each incoming address with those limits. It returns the channel, a one-hot chip select within that channel, and a flag for addresses that lie above all populated memory.

Addresses enter and results leave on valid/ready streams with one output register stage. An address is accepted when `in_valid` and `in_ready` are both high. Its result is presented on the next cycle and is held unchanged while the consumer keeps `out_ready` low. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A source must hold `in_valid` and `in_addr` steady until the address is accepted. The configuration port is plain: a single-cycle write strobe and a combinational read.

Top module: `rkdec_top`

## Requirements
- R1: After reset all eight boundary registers read 00h. Each one is written and read back at a fixed offset: 100h to 103h for channel 0 ranks 0 to 3, and 180h to 183h for channel 1 ranks 0 to 3.
- R2: A read of any other offset returns 00h. A write to any other offset changes no boundary register.
- R3: For an accepted address, the decoder takes the 7-bit field F = addr[31:25]. It selects the first rank, in the order channel 0 ranks 0..3 and then channel 1 ranks 0..3, whose boundary is strictly greater than F. It drives `out_chan` with that rank's channel (0 or 1) and `out_cs` with bit n set for rank n of that channel.
- R4: A rank whose boundary equals the boundary of the rank before it covers no addresses and is never selected.
- R5: If F is at or above every boundary, `out_oor` is 1, `out_cs` is 0000 and `out_chan` is 0. After reset every address is therefore out of range.
- R6: The result of an address accepted at a clock edge appears with `out_valid` high right after that edge. `out_valid` is low after reset.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the result outputs hold their values. When `out_ready` returns high, the next address is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Boundary register write strobe |
| cfg_wr_off | input | 12 | Write offset |
| cfg_wr_data | input | 8 | Write data |
| cfg_rd_off | input | 12 | Read offset |
| cfg_rd_data | output | 8 | Read data, combinational |
| in_valid | input | 1 | Address valid |
| in_ready | output | 1 | Decoder can take an address |
| in_addr | input | 32 | Physical address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_chan | output | 1 | Selected channel |
| out_cs | output | 4 | One-hot rank select within the channel |
| out_oor | output | 1 | Address above all ranks |

## Verification
The hold property assumes that the consumer may stall for any number of cycles. It also assumes that the source obeys the stream rule: address and valid stay fixed until accepted. The bench keeps `in_valid` and `in_addr` constant across a stall of several cycles. Boundary writes are assumed not to change during a decode that is being checked, so the bench programs all limits before it sends any address. The programmed limits include equal neighbours in both channels, which exercises the empty-rank case.

// File: rtl/rkdec_pkg.sv
package rkdec_pkg;
  localparam int RANKS_DEF  = 4;
  localparam int CHANS_DEF  = 2;
  localparam int BND_W_DEF  = 8;
  localparam int OFF_W_DEF  = 12;
  localparam int BASE_DEF   = 'h100;
  localparam int STRIDE_DEF = 'h080;

  function automatic int chan_width(input int chans);
    return (chans > 1) ? $clog2(chans) : 1;
  endfunction
endpackage

// File: rtl/rkdec_regs.sv
module rkdec_regs #(
  parameter int BND_W  = 8,
  parameter int RANKS  = 4,
  parameter int CHANS  = 2,
  parameter int OFF_W  = 12,
  parameter int BASE   = 'h100,
  parameter int STRIDE = 'h080
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [OFF_W-1:0]                    wr_off,
  input  logic [BND_W-1:0]                    wr_data,
  input  logic [OFF_W-1:0]                    rd_off,
  output logic [BND_W-1:0]                    rd_data,
  output logic [CHANS*RANKS-1:0][BND_W-1:0]   bnd
);
  localparam int NREG = CHANS * RANKS;

  logic [NREG-1:0] wr_hit;
  logic [NREG-1:0] rd_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(BASE + (g / RANKS) * STRIDE + (g % RANKS));
    logic [BND_W-1:0] q;

    assign wr_hit[g] = wr_en && (wr_off == MY_OFF);
    assign rd_hit[g] = (rd_off == MY_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (wr_hit[g]) q <= wr_data;
    end

    assign bnd[g] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_hit[i]) rd_data = rd_data | bnd[i];
    end
  end

  // R2: a write that hits no register leaves every boundary untouched
  p_stray_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_hit == '0)) |=> $stable(bnd));
endmodule

// File: rtl/rkdec_match.sv
module rkdec_match #(
  parameter int BND_W = 8,
  parameter int RANKS = 4,
  parameter int CHANS = 2,
  parameter int FLD_W = 7,
  parameter int CH_W  = 1
) (
  input  logic [FLD_W-1:0]                    fld,
  input  logic [CHANS*RANKS-1:0][BND_W-1:0]   bnd,
  output logic                                hit,
  output logic [CH_W-1:0]                     chan,
  output logic [RANKS-1:0]                    cs
);
  localparam int NREG = CHANS * RANKS;
  localparam int CW   = (FLD_W > BND_W) ? FLD_W : BND_W;

  logic [CW-1:0] fld_x;
  assign fld_x = CW'(fld);

  // Walk from the top rank down so the lowest matching rank is written last.
  always_comb begin
    hit  = 1'b0;
    chan = '0;
    cs   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (fld_x < CW'(bnd[i])) begin
        hit  = 1'b1;
        chan = CH_W'(i / RANKS);
        cs   = RANKS'(1) << (i % RANKS);
      end
    end
  end
endmodule

// File: rtl/rkdec_top.sv
module rkdec_top
  import rkdec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 25,
  parameter int BND_W    = BND_W_DEF,
  parameter int RANKS    = RANKS_DEF,
  parameter int CHANS    = CHANS_DEF,
  parameter int OFF_W    = OFF_W_DEF,
  parameter int BASE     = BASE_DEF,
  parameter int STRIDE   = STRIDE_DEF,
  localparam int CH_W    = chan_width(CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [OFF_W-1:0]  cfg_wr_off,
  input  logic [BND_W-1:0]  cfg_wr_data,
  input  logic [OFF_W-1:0]  cfg_rd_off,
  output logic [BND_W-1:0]  cfg_rd_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  output logic [RANKS-1:0]  out_cs,
  output logic              out_oor
);
  localparam int FLD_W = ADDR_W - GRAN_LSB;

  logic [CHANS*RANKS-1:0][BND_W-1:0] bnd;
  logic                              m_hit;
  logic [CH_W-1:0]                   m_chan;
  logic [RANKS-1:0]                  m_cs;

  rkdec_regs #(
    .BND_W(BND_W), .RANKS(RANKS), .CHANS(CHANS),
    .OFF_W(OFF_W), .BASE(BASE), .STRIDE(STRIDE)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_off  (cfg_wr_off),
    .wr_data (cfg_wr_data),
    .rd_off  (cfg_rd_off),
    .rd_data (cfg_rd_data),
    .bnd     (bnd)
  );

  rkdec_match #(
    .BND_W(BND_W), .RANKS(RANKS), .CHANS(CHANS),
    .FLD_W(FLD_W), .CH_W(CH_W)
  ) match_i (
    .fld  (in_addr[ADDR_W-1:GRAN_LSB]),
    .bnd  (bnd),
    .hit  (m_hit),
    .chan (m_chan),
    .cs   (m_cs)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_cs    <= '0;
      out_oor   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan <= m_chan;
        out_cs   <= m_cs;
        out_oor  <= !m_hit;
      end
    end
  end

  // R3: an in-range result names exactly one rank
  p_one_rank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_oor) |-> ($countones(out_cs) == 1));

  // R5: out-of-range results carry no chip select and channel 0
  p_oor_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_oor) |-> ((out_cs == '0) && (out_chan == '0)));

  // R6: an accepted address yields a valid result on the next cycle
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7: a stalled result stays put
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_cs) && $stable(out_chan) && $stable(out_oor)));
endmodule

// File: tb/rkdec_tb.sv
`timescale 1ns/1ps
module rkdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [11:0] cfg_wr_off = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic [11:0] cfg_rd_off = '0;
  logic [7:0]  cfg_rd_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [0:0]  out_chan;
  logic [3:0]  out_cs;
  logic        out_oor;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  rkdec_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_off(cfg_wr_off), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_off(cfg_rd_off), .cfg_rd_data(cfg_rd_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_chan(out_chan), .out_cs(out_cs), .out_oor(out_oor)
  );

  // {addr, empty-rank case, oor, chan, cs}
  localparam logic [38:0] VEC [0:11] = '{
    {32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'b0001},
    {32'h01FF_FFFF, 1'b0, 1'b0, 1'b0, 4'b0001},
    {32'h0200_0000, 1'b0, 1'b0, 1'b0, 4'b0010},
    {32'h0400_0000, 1'b1, 1'b0, 1'b0, 4'b0010},
    {32'h0600_0000, 1'b0, 1'b0, 1'b0, 4'b1000},
    {32'h0800_0000, 1'b0, 1'b0, 1'b1, 4'b0001},
    {32'h0BFF_FFFF, 1'b0, 1'b0, 1'b1, 4'b0001},
    {32'h0C00_0000, 1'b1, 1'b0, 1'b1, 4'b0100},
    {32'h0E00_0000, 1'b1, 1'b0, 1'b1, 4'b0100},
    {32'h1000_0000, 1'b0, 1'b0, 1'b1, 4'b1000},
    {32'h1400_0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 4'b0000}
  };

  localparam logic [11:0] OFFS [0:7] = '{12'h100, 12'h101, 12'h102, 12'h103,
                                        12'h180, 12'h181, 12'h182, 12'h183};
  localparam logic [7:0]  BNDS [0:7] = '{8'h01, 8'h03, 8'h03, 8'h04,
                                        8'h06, 8'h06, 8'h08, 8'h0A};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] off, input logic [7:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_off = off; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [11:0] off, output logic [7:0] data);
    @(negedge clk);
    cfg_rd_off = off;
    #1 data = cfg_rd_data;
  endtask

  // Drive one address with out_ready high; result sampled at the next negedge.
  task automatic send(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    chk("R6", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R7", "in_ready after reset", 32'(in_ready), 32'd1);
    for (int i = 0; i < 8; i++) begin
      cfg_read(OFFS[i], rd);
      chk("R1", "reset boundary", 32'(rd), 32'h00);
    end
    send(32'h0000_0000);
    chk("R5", "oor with zero boundaries", 32'(out_oor), 32'd1);
    chk("R5", "cs with zero boundaries", 32'(out_cs), 32'd0);

    // Program and read back
    for (int i = 0; i < 8; i++) cfg_write(OFFS[i], BNDS[i]);
    for (int i = 0; i < 8; i++) begin
      cfg_read(OFFS[i], rd);
      chk("R1", "boundary readback", 32'(rd), 32'(BNDS[i]));
    end

    // Unmapped offsets
    cfg_write(12'h104, 8'h55);
    cfg_write(12'h17F, 8'h66);
    cfg_write(12'h000, 8'h77);
    cfg_read(12'h104, rd);
    chk("R2", "unmapped read 104", 32'(rd), 32'h00);
    cfg_read(12'h000, rd);
    chk("R2", "unmapped read 000", 32'(rd), 32'h00);
    cfg_read(12'h103, rd);
    chk("R2", "neighbour 103 untouched", 32'(rd), 32'h04);
    cfg_read(12'h180, rd);
    chk("R2", "neighbour 180 untouched", 32'(rd), 32'h06);

    // Vector walk
    for (int v = 0; v < 12; v++) begin
      logic [31:0] a;
      logic emp, oor, ch;
      logic [3:0] cs;
      {a, emp, oor, ch, cs} = VEC[v];
      send(a);
      chk("R6", "valid one cycle after accept", 32'(out_valid), 32'd1);
      if (oor) begin
        chk("R5", "oor flag", 32'(out_oor), 32'd1);
        chk("R5", "oor cs", 32'(out_cs), 32'd0);
        chk("R5", "oor chan", 32'(out_chan), 32'd0);
      end else if (emp) begin
        chk("R4", "skips empty rank cs", 32'(out_cs), 32'(cs));
        chk("R4", "skips empty rank chan", 32'(out_chan), 32'(ch));
        chk("R4", "oor flag", 32'(out_oor), 32'd0);
      end else begin
        chk("R3", "rank cs", 32'(out_cs), 32'(cs));
        chk("R3", "rank chan", 32'(out_chan), 32'(ch));
        chk("R3", "oor flag", 32'(out_oor), 32'd0);
      end
    end
    @(negedge clk);
    chk("R6", "valid drops when idle", 32'(out_valid), 32'd0);

    // Back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(32'h0000_0000);
    in_valid = 1'b1; in_addr = 32'h1000_0000;
    #1 chk("R7", "in_ready low when stalled", 32'(in_ready), 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R7", "held valid", 32'(out_valid), 32'd1);
      chk("R7", "held cs", 32'(out_cs), 32'b0001);
      chk("R7", "held chan", 32'(out_chan), 32'd0);
    end
    out_ready = 1'b1;
    #1 chk("R7", "in_ready with drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "next result cs", 32'(out_cs), 32'b1000);
    chk("R7", "next result chan", 32'(out_chan), 32'd1);
    chk("R7", "next result valid", 32'(out_valid), 32'd1);

    @(negedge clk);
    finish_run();
  end
endmodule